// File: doc/BRIEF.md
# Flash Erase/Program Status Controller

This block is the command-and-status engine of a small parallel flash part. It watches the chip-enable, write-enable and output-enable strobes. It takes program and sector-erase requests, times the operation in clock cycles, and answers status reads with a polling byte.

A program request makes the controller busy for a fixed number of cycles. A sector-erase request does not start the erase at once. It first opens a collection window, and during that window more sector-erase requests can be added to a per-sector bitmap. When the window closes, every collected sector is erased together.

If the target of a program is not blank, the operation never finishes. Once the time limit passes, the controller reports a failure and stays locked until a reset command arrives. A low-supply flag drops the controller back to read mode at any time.

Top module: `flash_status_ctrl`

## Requirements
- R1: A write is taken once per strobe, on the first cycle in which ce_n=0, we_n=0 and oe_n=1 all hold. Holding oe_n low, ce_n high or we_n high inhibits writes. The command codes on op are 2'b01 program (data on din), 2'b10 sector erase (sector number on sector_idx), 2'b11 reset and 2'b00 none.
- R2: While supply_ok is 0, the controller returns to read mode, the sector bitmap is cleared, and writes are ignored.
- R3: In read mode a read (ce_n=0, oe_n=0, we_n=1) returns array_data. When no read is active, dout is 8'h00.
- R4: While a program is busy, the status byte has bit 7 equal to the complement of din[7], with bit 5=0 and bit 3=0. When blank_n=0 at acceptance, the controller returns to read mode PROG_CYC cycles after acceptance.
- R5: In every state other than read mode, bit 6 of the status byte inverts between successive reads.
- R6: The first sector erase opens a window in which bit 3=0 and bit 7=0. After WIN_CYC cycles with no further sector erase, the erase starts and bit 3 reads 1.
- R7: A sector erase taken while the window is open sets that sector's bit in the bitmap and restarts the window. erase_set shows the bitmap (bit i is sector i) only during the erase phase, and is 0 otherwise.
- R8: During the erase phase or a program, every command is ignored. The erase lasts ERASE_CYC cycles and then the controller returns to read mode.
- R9: A program accepted with blank_n=1 never completes. Bit 5 reads 0 until LIMIT_CYC cycles have passed and 1 after that, and bit 7 keeps the complement of din[7].
- R10: After a time-limit failure, only a reset command returns the controller to read mode, which clears bit 5. Program and erase commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | 1 when supply is above lockout level |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op | input | 2 | Command code presented with a write |
| din | input | 8 | Program data |
| sector_idx | input | $clog2(NSECT) | Sector number for sector erase |
| blank_n | input | 1 | 1 when the program target is not blank |
| array_data | input | 8 | Array read data (stub) |
| dout | output | 8 | Read data or status byte |
| erase_set | output | NSECT | Sectors being erased, valid during the erase phase |

## Verification
The bench builds the block with NSECT=8, WIN_CYC=20, ERASE_CYC=30, PROG_CYC=10 and LIMIT_CYC=60. With these values a full erase, a window restart and the time-limit lockout each take only a few dozen cycles. Because the window is short, one extra sector erase timed a few cycles after the first decides between a restarted and an unrestarted window through a single bit-3 read. Because the limit is small, the failure and the recovery by reset command are also reached quickly.

// File: rtl/fsc_pkg.sv
// Shared types and constants for the flash status controller.
// Assumes: status bit positions are fixed by the host polling routine.
package fsc_pkg;

    typedef enum logic [2:0] {
        ST_READ   = 3'd0,
        ST_WINDOW = 3'd1,
        ST_ERASE  = 3'd2,
        ST_PROG   = 3'd3,
        ST_FAIL   = 3'd4
    } fsc_state_e;

    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_PROG  = 2'b01;
    localparam logic [1:0] OP_ERASE = 2'b10;
    localparam logic [1:0] OP_RESET = 2'b11;

    localparam int BIT_POLL  = 7;
    localparam int BIT_TOG   = 6;
    localparam int BIT_LIMIT = 5;
    localparam int BIT_WIN   = 3;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsc_strobe.sv
// Strobe decoder: turns the three active-low bus strobes into a one-cycle
// write event, a read-active level and a one-cycle read-start event.
// Assumes: strobes are already synchronous to clk.
module fsc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_evt,
    output logic rd_act,
    output logic rd_evt
);
    logic wr_cond;
    logic wr_q;
    logic rd_q;

    // Decode the write and read bus conditions.
    assign wr_cond = !ce_n && !we_n && oe_n;
    assign rd_act  = !ce_n && !oe_n && we_n;

    // Remember last cycle's conditions for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_cond;
            rd_q <= rd_act;
        end
    end

    // One event per strobe assertion.
    assign wr_evt = wr_cond && !wr_q;
    assign rd_evt = rd_act && !rd_q;

    AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R1

endmodule

// File: rtl/fsc_seq.sv
// Operation sequencer: accepts commands, keeps the sector bitmap, runs the
// erase window, busy timers and time-limit lockout.
// Assumes: a single counter serves the window and the busy phase.
module fsc_seq
    import fsc_pkg::*;
#(
    parameter int NSECT     = 8,
    parameter int WIN_CYC   = 2500,
    parameter int ERASE_CYC = 50000,
    parameter int PROG_CYC  = 350,
    parameter int LIMIT_CYC = 200000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     supply_ok,
    input  logic                     wr_evt,
    input  logic [1:0]               op,
    input  logic                     din_msb,
    input  logic [$clog2(NSECT)-1:0] sector_idx,
    input  logic                     blank_n,
    output fsc_state_e               state,
    output logic                     poll_bit,
    output logic [NSECT-1:0]         erase_set
);
    localparam int MAXC = imax(imax(WIN_CYC, ERASE_CYC), imax(PROG_CYC, LIMIT_CYC));
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WIN_END   = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] ERASE_END = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] PROG_END  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] LIM_END   = CW'(LIMIT_CYC - 1);

    fsc_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [NSECT-1:0] map_q, map_d;
    logic [NSECT-1:0] sel_one;
    logic             poll_q, poll_d;
    logic             nb_q, nb_d;

    // One-hot mask of the addressed sector.
    assign sel_one = {{(NSECT-1){1'b0}}, 1'b1} << sector_idx;

    // Next-state, counter and bitmap decision.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q + CW'(1);
        map_d  = map_q;
        poll_d = poll_q;
        nb_d   = nb_q;
        unique case (st_q)
            ST_READ: begin
                cnt_d = '0;
                if (wr_evt && op == OP_PROG) begin
                    st_d   = ST_PROG;
                    poll_d = !din_msb;
                    nb_d   = blank_n;
                end else if (wr_evt && op == OP_ERASE) begin
                    st_d   = ST_WINDOW;
                    map_d  = sel_one;
                    poll_d = 1'b0;
                end
            end
            ST_WINDOW: begin
                if (wr_evt && op == OP_ERASE) begin
                    map_d = map_q | sel_one;
                    cnt_d = '0;
                end else if (cnt_q == WIN_END) begin
                    st_d  = ST_ERASE;
                    cnt_d = '0;
                end
            end
            ST_ERASE: begin
                if (cnt_q == ERASE_END)    st_d = ST_READ;
                else if (cnt_q == LIM_END) st_d = ST_FAIL;
            end
            ST_PROG: begin
                if (!nb_q && cnt_q == PROG_END) st_d = ST_READ;
                else if (cnt_q == LIM_END)      st_d = ST_FAIL;
            end
            ST_FAIL: begin
                cnt_d = cnt_q;
                if (wr_evt && op == OP_RESET) st_d = ST_READ;
            end
            default: st_d = ST_READ;
        endcase
        if (st_d == ST_READ) map_d = '0;
        if (!supply_ok) begin
            st_d  = ST_READ;
            map_d = '0;
            cnt_d = '0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_READ;
            cnt_q  <= '0;
            map_q  <= '0;
            poll_q <= 1'b0;
            nb_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            map_q  <= map_d;
            poll_q <= poll_d;
            nb_q   <= nb_d;
        end
    end

    assign state     = st_q;
    assign poll_bit  = poll_q;
    assign erase_set = (st_q == ST_ERASE) ? map_q : '0;

    AST_IDLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ && !wr_evt) |=> st_q == ST_READ); // R1
    AST_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (st_q == ST_READ && map_q == '0)); // R2
    AST_ERASE_HAS_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_ERASE |-> map_q != '0); // R7
    AST_ERASE_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERASE && supply_ok) |=> ($stable(map_q) || st_q == ST_READ)); // R8
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAIL && supply_ok && !(wr_evt && op == OP_RESET)) |=> st_q == ST_FAIL); // R10

endmodule

// File: rtl/fsc_status.sv
// Read-data path: builds the polling status byte and keeps the toggle bit.
// Assumes: any state other than read mode answers reads with status.
module fsc_status
    import fsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fsc_state_e state,
    input  logic       poll_bit,
    input  logic       rd_act,
    input  logic       rd_evt,
    input  logic [7:0] array_data,
    output logic [7:0] dout
);
    logic       busy;
    logic       tog_q;
    logic [7:0] stat;

    assign busy = (state != ST_READ);

    // Toggle bit inverts at the start of each read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog_q <= 1'b0;
        else if (rd_evt && busy) tog_q <= !tog_q;
    end

    // Assemble the status byte.
    always_comb begin
        stat            = 8'h00;
        stat[BIT_POLL]  = poll_bit;
        stat[BIT_TOG]   = tog_q;
        stat[BIT_LIMIT] = (state == ST_FAIL);
        stat[BIT_WIN]   = (state == ST_ERASE);
    end

    // Output mux: nothing, array data or status.
    assign dout = !rd_act ? 8'h00 : (busy ? stat : array_data);

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && busy) |=> tog_q != $past(tog_q)); // R5
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> dout == 8'h00); // R3

endmodule

// File: rtl/flash_status_ctrl.sv
// Top: flash erase/program status controller. Ties the strobe decoder,
// operation sequencer and status read path together.
// Assumes: array contents are outside; array_data is a stub read port.
module flash_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NSECT     = 8,
    parameter int WIN_CYC   = 2500,
    parameter int ERASE_CYC = 50000,
    parameter int PROG_CYC  = 350,
    parameter int LIMIT_CYC = 200000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     supply_ok,
    input  logic                     ce_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [1:0]               op,
    input  logic [7:0]               din,
    input  logic [$clog2(NSECT)-1:0] sector_idx,
    input  logic                     blank_n,
    input  logic [7:0]               array_data,
    output logic [7:0]               dout,
    output logic [NSECT-1:0]         erase_set
);
    logic       wr_evt, rd_act, rd_evt, poll_bit;
    logic       wr_ok;
    fsc_state_e state;
    logic       unused_din;

    // Only the top data bit matters for polling.
    assign unused_din = ^din[6:0];
    // Writes are locked out while supply is low.
    assign wr_ok = wr_evt && supply_ok;

    fsc_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_evt(wr_evt), .rd_act(rd_act), .rd_evt(rd_evt)
    );

    fsc_seq #(
        .NSECT(NSECT), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC),
        .PROG_CYC(PROG_CYC), .LIMIT_CYC(LIMIT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_evt(wr_ok),
        .op(op), .din_msb(din[7]), .sector_idx(sector_idx), .blank_n(blank_n),
        .state(state), .poll_bit(poll_bit), .erase_set(erase_set)
    );

    fsc_status u_status (
        .clk(clk), .rst_n(rst_n), .state(state), .poll_bit(poll_bit),
        .rd_act(rd_act), .rd_evt(rd_evt), .array_data(array_data), .dout(dout)
    );

endmodule

// File: tb/flash_status_ctrl_tb_top.sv
module flash_status_ctrl_tb_top;
    localparam int NSECT = 8;
    localparam int SW    = $clog2(NSECT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0] op = 2'b00;
    logic [7:0] din = 8'h00;
    logic [SW-1:0] sector_idx = '0;
    logic blank_n = 1'b0;
    logic [7:0] array_data = 8'hC3;
    logic [7:0] dout;
    logic [NSECT-1:0] erase_set;

    int total = 0;
    int bad = 0;
    logic [7:0] r1, r2;

    always #10 clk = !clk;

    flash_status_ctrl #(
        .NSECT(NSECT), .WIN_CYC(20), .ERASE_CYC(30), .PROG_CYC(10), .LIMIT_CYC(60)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .op(op), .din(din), .sector_idx(sector_idx), .blank_n(blank_n),
        .array_data(array_data), .dout(dout), .erase_set(erase_set)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] o, input logic [7:0] d, input logic [SW-1:0] s);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; op = o; din = d; sector_idx = s;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; op = 2'b00;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 v = dout;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        #1 chk("R3 idle bus", dout, 8'h00);
        chk("R7 no erase at reset", 8'(erase_set), 8'h00);
        rd(r1);
        chk("R3 read mode data", r1, 8'hC3);
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; op = 2'b01; din = 8'h00;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; op = 2'b00;
        rd(r1);
        chk("R1 oe low inhibits", r1, 8'hC3);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b0; op = 2'b10;
        @(negedge clk);
        we_n = 1'b1; op = 2'b00;
        rd(r1);
        chk("R1 ce high inhibits", r1, 8'hC3);
    endtask

    task automatic t_program_ok();
        blank_n = 1'b0;
        wr(2'b01, 8'h5A, '0);
        rd(r1);
        rd(r2);
        chk("R4 busy poll/limit/window bits", r1 & 8'hA8, 8'h80);
        chk("R5 toggle during program", r1 ^ r2, 8'h40);
        idle(12);
        rd(r1);
        chk("R4 back to read after program", r1, 8'hC3);
    endtask

    task automatic t_erase_queue();
        wr(2'b10, 8'h00, SW'(2));
        rd(r1);
        chk("R6 window open bits", r1 & 8'hA8, 8'h00);
        wr(2'b10, 8'h00, SW'(5));
        chk("R7 erase_set idle in window", 8'(erase_set), 8'h00);
        idle(17);
        rd(r1);
        chk("R7 window restarted by extra erase", r1 & 8'h08, 8'h00);
        idle(1);
        rd(r1);
        chk("R6 erase started", r1 & 8'h88, 8'h08);
        chk("R7 queued sectors", 8'(erase_set), 8'h24);
        wr(2'b10, 8'h00, SW'(7));
        wr(2'b01, 8'h00, '0);
        #1 chk("R8 commands ignored during erase", 8'(erase_set), 8'h24);
        rd(r1);
        chk("R8 still erasing", r1 & 8'h08, 8'h08);
        idle(25);
        rd(r1);
        chk("R8 erase completes to read", r1, 8'hC3);
        chk("R7 bitmap released", 8'(erase_set), 8'h00);
    endtask

    task automatic t_program_stuck();
        blank_n = 1'b1;
        wr(2'b01, 8'h3C, '0);
        blank_n = 1'b0;
        rd(r1);
        chk("R9 no limit flag yet", r1 & 8'hA0, 8'h80);
        idle(62);
        rd(r1);
        rd(r2);
        chk("R9 limit flag set", r1 & 8'hA8, 8'hA0);
        chk("R5 toggle during failure", r1 ^ r2, 8'h40);
        wr(2'b01, 8'h00, '0);
        wr(2'b10, 8'h00, SW'(1));
        rd(r1);
        chk("R10 other commands ignored", r1 & 8'h20, 8'h20);
        wr(2'b11, 8'h00, '0);
        rd(r1);
        chk("R10 reset clears failure", r1, 8'hC3);
    endtask

    task automatic t_supply_drop();
        wr(2'b10, 8'h00, SW'(1));
        wr(2'b10, 8'h00, SW'(3));
        idle(22);
        #1 chk("R7 erase set before drop", 8'(erase_set), 8'h0A);
        supply_ok = 1'b0;
        idle(1);
        #1 chk("R2 bitmap cleared", 8'(erase_set), 8'h00);
        wr(2'b01, 8'h00, '0);
        rd(r1);
        chk("R2 read mode and write ignored", r1, 8'hC3);
        supply_ok = 1'b1;
        rd(r1);
        chk("R2 stays in read after recovery", r1, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_inhibit();
        t_program_ok();
        t_erase_queue();
        t_program_stuck();
        t_supply_drop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule